// File: doc/BRIEF.md
# Edge-Triggered Interrupt Concentrator with Message Signalling

The block collects eleven interrupt request lines from peripherals and turns them into one memory-write style message towards a processor. Each line is first brought into the local clock domain by a two-stage synchroniser. A rising edge on a line whose enable bit is set marks that line in a pending register. Whenever pending work exists and the message engine is armed, one message is issued. The message carries the 32-bit word that the host has programmed into the target register.

The message engine is a three-state machine. IDLE waits for a pending bit; the transition *fire* (pending non-zero) enters SEND. SEND holds `msg_valid` with a word captured on entry until the receiver accepts it; the transition *accepted* (`msg_ready` high) enters WAIT. WAIT sends nothing more until the host reads the request register; the transition *rearm* goes back to IDLE. If pending bits remain at that point, IDLE fires again on the next cycle.

The host reaches the block through a small word-indexed register port with combinational read data. Index 0 is the target word, 1 the request register, 2 the enable mask, 3 the pending register, and 4 the live synchronised levels. Reading the request or pending register returns the pending bits and clears them, but only the request read re-arms the engine. A host can compare the live levels with the enables to find sources that are still asserted and serve them again.

Top module: `irq_msg_concentrator`

## Requirements
- R1: After reset the target, mask, pending and request registers read zero and `msg_valid` is low.
- R2: The level register (index 4) shows each implemented input line, bit n for line n, two clocks after the line changes.
- R3: Only a rising edge on line n while mask bit n is set sets pending bit n. Falling edges and edges on masked lines set nothing.
- R4: A line that is already high when its mask bit is set produces no pending bit and no message.
- R5: A message presents, on `msg_data`, the target word as it stood when the message started. `msg_valid` and that word stay stable until `msg_ready` is seen high.
- R6: After a message is accepted, no further message is issued until the request register (index 1) is read. New pending bits then produce exactly one new message.
- R7: Reading the request register returns the pending bits and clears them.
- R8: Reading the pending register (index 3) returns and clears the pending bits. It leaves the level register unchanged and does not re-arm the message engine.
- R9: Line 9 is unimplemented (implemented set 0x5FF). Its bit always reads zero in the level, pending and request registers.
- R10: A rising edge registered in the same clock as a clearing read stays pending, and it triggers the message that follows the re-arm.
- R11: The target register reads back as written. The mask register keeps bits 0 to 10 and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Asynchronous interrupt lines |
| host_addr | input | 3 | Register word index |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clearing reads act at the clock edge) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_data | output | 32 | Message word |

## Verification
The assertions assume that the host never writes and reads in the same cycle. They also assume that `msg_ready` is only meaningful while a message is offered. The stall check further relies on the receiver dropping `msg_ready` for whole cycles. The stimulus changes the lines and strobes only just after a falling clock edge, and it keeps every strobe to a single cycle. The target word is rewritten during a stall on purpose, to show that the offered message does not follow the register.

// File: rtl/irqcat_pkg.sv
package irqcat_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_TARGET  = 3'd0,
        REG_REQUEST = 3'd1,
        REG_MASK    = 3'd2,
        REG_PENDING = 3'd3,
        REG_LEVEL   = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } msg_state_e;
endpackage

// File: rtl/irqcat_line_sync.sv
module irqcat_line_sync #(
    parameter int LINES  = 11,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise
);
    logic [LINES-1:0] stage_q [STAGES];
    logic [LINES-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign level = stage_q[STAGES-1];
    assign rise  = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqcat_msg_fsm.sv
module irqcat_msg_fsm
    import irqcat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_any,
    input  logic          rearm,
    input  logic [DW-1:0] target,
    input  logic          msg_ready,
    output logic          msg_valid,
    output logic [DW-1:0] msg_data
);
    msg_state_e state_q, state_d;
    logic [DW-1:0] word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pend_any)  state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_WAIT;
            ST_WAIT: if (rearm)     state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_SEND) word_q <= target;
        end
    end

    always_comb begin
        msg_valid = 1'b0;
        msg_data  = '0;
        unique case (state_q)
            ST_SEND: begin
                msg_valid = 1'b1;
                msg_data  = word_q;
            end
            default: ;
        endcase
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));

    // R6
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: rtl/irq_msg_concentrator.sv
module irq_msg_concentrator
    import irqcat_pkg::*;
#(
    parameter int          LINES       = 11,
    parameter int          DW          = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [10:0] IMPL_BITS   = 11'h5FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic [REG_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [DW-1:0]     msg_data
);
    localparam logic [LINES-1:0] IMPL = LINES'(IMPL_BITS);

    logic [LINES-1:0] level, rise, set_bits;
    logic [LINES-1:0] mask_q, pend_q;
    logic [DW-1:0]    target_q;
    logic             rd_req, rd_pend, pend_clr;

    irqcat_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (irq_in),
        .level (level),
        .rise  (rise)
    );

    assign set_bits = rise & mask_q & IMPL;
    assign rd_req   = host_rd && (host_addr == REG_REQUEST);
    assign rd_pend  = host_rd && (host_addr == REG_PENDING);
    assign pend_clr = rd_req || rd_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            mask_q   <= '0;
            pend_q   <= '0;
        end else begin
            if (host_wr && host_addr == REG_TARGET) target_q <= host_wdata;
            if (host_wr && host_addr == REG_MASK)   mask_q   <= host_wdata[LINES-1:0];
            pend_q <= (pend_clr ? '0 : pend_q) | set_bits;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (reg_idx_e'(host_addr))
            REG_TARGET:  host_rdata = target_q;
            REG_REQUEST: host_rdata = DW'(pend_q);
            REG_MASK:    host_rdata = DW'(mask_q);
            REG_PENDING: host_rdata = DW'(pend_q);
            REG_LEVEL:   host_rdata = DW'(level & IMPL);
            default:     host_rdata = '0;
        endcase
    end

    irqcat_msg_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (|pend_q),
        .rearm     (rd_req),
        .target    (target_q),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_data  (msg_data)
    );

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~IMPL) == '0);

    // R3
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((pend_q & $past(set_bits)) == $past(set_bits)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr |=> ((pend_q & ~$past(set_bits)) == '0));
endmodule

// File: tb/irq_msg_concentrator_test.sv
module irq_msg_concentrator_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_in = '0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_data;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] exp_q [$];

    always #(PERIOD/2) clk = ~clk;

    irq_msg_concentrator uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_msg(input logic [31:0] word);
        exp_q.push_back(word);
    endtask

    // monitor: pops the scoreboard on every accepted message
    always @(negedge clk) begin
        #(PERIOD/4);
        if (rst_n && msg_valid && msg_ready) begin
            if (exp_q.size() == 0) check("R6 unexpected message", msg_data, 32'hxxxx_xxxx);
            else check("R5 message word", msg_data, exp_q.pop_front());
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #(PERIOD/4) check(req, host_rdata, exp);
        @(posedge clk); #1 host_rd = 1'b0;
    endtask

    initial begin
        #(PERIOD * 20000);
        check("watchdog expired", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        // R1 reset state
        host_read(3'd1, 32'h0, "R1 request");
        host_read(3'd2, 32'h0, "R1 mask");
        host_read(3'd3, 32'h0, "R1 pending");
        host_read(3'd0, 32'h0, "R1 target");
        check("R1 msg_valid", 32'(msg_valid), 32'h0);

        // R11 register readback
        host_write(3'd0, 32'h1234_5678);
        host_read(3'd0, 32'h1234_5678, "R11 target");
        host_write(3'd2, 32'hFFFF_FFFF);
        host_read(3'd2, 32'h0000_07FF, "R11 mask");

        // first message, R2 level, R7 clearing read
        expect_msg(32'h1234_5678);
        @(negedge clk); irq_in = 11'h001;
        settle(8);
        host_read(3'd4, 32'h001, "R2 level");
        host_read(3'd1, 32'h001, "R7 request value");
        host_read(3'd1, 32'h000, "R7 request cleared");

        // R6 / R8: one message, then silence until request read
        expect_msg(32'h1234_5678);
        @(negedge clk); irq_in = 11'h009;
        settle(8);
        @(negedge clk); irq_in = 11'h049;
        settle(8);
        host_read(3'd3, 32'h048, "R8 pending value");
        host_read(3'd4, 32'h049, "R8 level unchanged");
        host_read(3'd3, 32'h000, "R8 pending cleared");
        @(negedge clk); irq_in = 11'h069;
        settle(8);
        check("R8 no rearm by pending read", 32'(msg_valid), 32'h0);
        host_read(3'd1, 32'h020, "R6 request rearm");
        expect_msg(32'h1234_5678);
        @(negedge clk); irq_in = 11'h06B;
        settle(8);
        host_read(3'd1, 32'h002, "R6 new message after rearm");

        // R3 falling and masked edges, R4 unmask of a high line
        @(negedge clk); irq_in = 11'h000;
        settle(8);
        host_read(3'd3, 32'h000, "R3 falling edge ignored");
        host_write(3'd2, 32'h0);
        @(negedge clk); irq_in = 11'h004;
        settle(8);
        host_read(3'd3, 32'h000, "R3 masked edge ignored");
        host_write(3'd2, 32'h7FF);
        settle(8);
        host_read(3'd3, 32'h000, "R4 unmask high line");
        check("R4 no message", 32'(msg_valid), 32'h0);
        host_read(3'd4, 32'h004, "R2 level high line");

        // R5 stall: word held, target rewrite does not leak
        @(negedge clk); msg_ready = 1'b0;
        expect_msg(32'h1234_5678);
        irq_in = 11'h014;
        settle(8);
        check("R5 valid during stall", 32'(msg_valid), 32'h1);
        check("R5 word during stall", msg_data, 32'h1234_5678);
        host_write(3'd0, 32'hCAFE_0001);
        settle(3);
        check("R5 word stable after target write", msg_data, 32'h1234_5678);
        @(negedge clk); msg_ready = 1'b1;
        settle(4);

        // R10 edge coincident with the clearing request read
        expect_msg(32'hCAFE_0001);
        @(negedge clk); irq_in = 11'h094;
        @(negedge clk);
        host_read(3'd1, 32'h010, "R10 read during edge");
        settle(8);
        host_read(3'd1, 32'h080, "R10 edge kept pending");

        // R9 unimplemented line 9
        @(negedge clk); irq_in = 11'h000;
        settle(8);
        expect_msg(32'hCAFE_0001);
        @(negedge clk); irq_in = 11'h7FF;
        settle(8);
        host_read(3'd4, 32'h5FF, "R9 level");
        host_read(3'd1, 32'h5FF, "R9 request");

        settle(10);
        check("R6 all expected messages seen", 32'(exp_q.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule